// File: doc/BRIEF.md
# UART Register Front-End

This block is the processor-facing side of a small UART. It exposes four 32-bit registers in a 16-byte window on a simple bus that completes every read and write in a single cycle. Received bytes arrive on a valid/ready byte stream and wait in an 8-entry FIFO until software reads them. Transmit bytes leave through a one-entry holding register onto a second valid/ready byte stream. A serializer with bit timing, framing and line drivers can therefore be attached later without changing this block.

Software polls a status word or waits on a level interrupt. A pending flag inside the block is raised when the receive FIFO holds data and on every transmit write. The interrupt output is this flag ANDed with an enable bit in the control word. A status read clears the flag once the FIFO has drained.

Top module: `uart_regfile`

## Requirements
- R1: The register index is `bus_addr_i[3:2]`: 0 is receive data, 1 is transmit data, 2 is status and 3 is control. A control write stores all 32 bits, and a control read returns the stored word. Read data is valid combinationally in the cycle the read is asserted. At most one of `bus_re_i` and `bus_we_i` is high in any cycle.
- R2: Received bytes are kept in first-in first-out order, up to 8 entries. `rx_ready_o` is high exactly while fewer than 8 bytes are held. A read of index 0 returns the oldest byte in bits 7:0, with the upper bits zero, and removes that byte.
- R3: A read of index 0 while the FIFO is empty returns 0 and leaves the FIFO empty.
- R4: A byte offered on `rx_valid_i` while the FIFO holds 8 entries is discarded. The discard sets the overrun flag (status bit 5). The flag stays set until a receive reset.
- R5: Status reads as follows: bit 0 = FIFO non-empty, bit 1 = FIFO full, bit 2 = transmit holding empty, bit 3 = transmit holding occupied, bit 4 = interrupt pending, bit 5 = overrun. All other bits read 0. Writes to index 2 have no effect.
- R6: A control write with bit 1 set empties the receive FIFO and clears overrun, and it discards any byte pushed in the same cycle.
- R7: When the holding register is empty, a write to index 1 loads `bus_wdata_i[7:0]`. `tx_valid_o` rises in the next cycle and stays high with stable `tx_data_o` until a cycle in which `tx_ready_i` is high. A write while the register is occupied is ignored. A read of index 1 returns the last loaded byte.
- R8: A control write with bit 0 set empties the transmit holding register.
- R9: The pending flag is set in any cycle that leaves the FIFO non-empty and on every write to index 1. A status read clears the flag only if the FIFO is empty after that cycle.
- R10: `irq_o` equals the pending flag ANDed with control bit 4.
- R11: After reset the FIFO and holding register are empty, control is 0, pending and overrun are clear, `rx_ready_o` is high, and `tx_valid_o` and `irq_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 4 | Byte address within the window |
| bus_re_i | input | 1 | Read strobe |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational |
| rx_data_i | input | 8 | Incoming byte |
| rx_valid_i | input | 1 | Incoming byte offered |
| rx_ready_o | output | 1 | FIFO can accept a byte |
| tx_data_o | output | 8 | Outgoing byte |
| tx_valid_o | output | 1 | Holding register occupied |
| tx_ready_i | input | 1 | Sink takes the outgoing byte |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench targets the following corner cases, each with the failure it would expose:
- **Full FIFO.** A ninth byte arrives while the FIFO is full. A design that overwrote the oldest entry would return a wrong first byte. A design that forgot the flag would show overrun clear.
- **Pointer wrap.** The FIFO is filled and drained across its wrap point. A read position computed with the wrong modulus returns bytes out of order.
- **Empty read.** A design that decremented past zero would report a huge occupancy and drop `rx_ready_o`.
- **Pending flag.** It is tested against a status read while bytes remain, and against a transmit write with interrupts disabled and then enabled. Clearing the flag too eagerly loses interrupts; never clearing it leaves `irq_o` stuck.
- **Same-cycle collisions.** These include a push alongside a pop, a push alongside a receive reset, and a drain alongside a second transmit write. A random phase repeats all of these against the reference model.

// File: rtl/uart_regfile_pkg.sv
package uart_regfile_pkg;
  typedef enum logic [1:0] {
    REG_RXD  = 2'd0,
    REG_TXD  = 2'd1,
    REG_STAT = 2'd2,
    REG_CTRL = 2'd3
  } reg_idx_e;

  localparam int unsigned ST_RX_AVAIL = 0;
  localparam int unsigned ST_RX_FULL  = 1;
  localparam int unsigned ST_TX_EMPTY = 2;
  localparam int unsigned ST_TX_FULL  = 3;
  localparam int unsigned ST_PEND     = 4;
  localparam int unsigned ST_OVERRUN  = 5;

  localparam int unsigned CT_TX_CLR   = 0;
  localparam int unsigned CT_RX_CLR   = 1;
  localparam int unsigned CT_IRQ_EN   = 4;
endpackage

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter  int unsigned DEPTH = 8,
  parameter  int unsigned DW    = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             push_valid_i,
  input  logic [DW-1:0]    push_data_i,
  output logic             push_ready_o,
  input  logic             pop_i,
  output logic [DW-1:0]    head_o,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] count_next_o,
  output logic             drop_o
);
  logic [DW-1:0]    mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rd_idx;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full, push_fire, pop_fire;

  assign full         = (cnt_q == CNT_W'(DEPTH));
  assign push_ready_o = !full;
  assign push_fire    = push_valid_i && !full && !clear_i;
  assign pop_fire     = pop_i && (cnt_q != '0) && !clear_i;
  assign drop_o       = push_valid_i && full;
  // oldest entry sits occupancy slots behind the write pointer
  assign rd_idx       = wptr_q - PTR_W'(cnt_q);
  assign head_o       = mem_q[rd_idx];
  assign count_o      = cnt_q;
  assign count_next_o = cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)                   cnt_d = '0;
    else if (push_fire && !pop_fire) cnt_d = cnt_q + CNT_W'(1);
    else if (pop_fire && !push_fire) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (clear_i)        wptr_q <= '0;
      else if (push_fire) wptr_q <= wptr_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_fire) mem_q[wptr_q] <= push_data_i;
  end
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          load_i,
  input  logic [DW-1:0] load_data_i,
  output logic          out_valid_o,
  output logic [DW-1:0] out_data_o,
  input  logic          out_ready_i
);
  logic          full_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (clear_i) begin
      full_q <= 1'b0;
    end else if (!full_q) begin
      if (load_i) begin
        full_q <= 1'b1;
        data_q <= load_data_i;
      end
    end else if (out_ready_i) begin
      full_q <= 1'b0;
    end
  end

  assign out_valid_o = full_q;
  assign out_data_o  = data_q;
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_regfile_pkg::*;
#(
  parameter  int unsigned RX_DEPTH = 8,
  parameter  int unsigned BYTE_W   = 8,
  parameter  int unsigned DATA_W   = 32,
  localparam int unsigned CNT_W    = $clog2(RX_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        bus_addr_i,
  input  logic              bus_re_i,
  input  logic              bus_we_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [BYTE_W-1:0] rx_data_i,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic              irq_o
);
  reg_idx_e          idx;
  logic              wr_txd, wr_ctrl, rd_rxd, rd_stat, rx_clr, tx_clr;
  logic [BYTE_W-1:0] rx_head;
  logic [CNT_W-1:0]  rx_cnt, rx_cnt_nxt;
  logic              rx_drop;
  logic [DATA_W-1:0] ctrl_q, stat;
  logic              pend_q, ovr_q;
  logic              unused_addr;

  assign idx         = reg_idx_e'(bus_addr_i[3:2]);
  assign unused_addr = ^bus_addr_i[1:0];
  assign wr_txd      = bus_we_i && (idx == REG_TXD);
  assign wr_ctrl     = bus_we_i && (idx == REG_CTRL);
  assign rd_rxd      = bus_re_i && (idx == REG_RXD);
  assign rd_stat     = bus_re_i && (idx == REG_STAT);
  assign rx_clr      = wr_ctrl && bus_wdata_i[CT_RX_CLR];
  assign tx_clr      = wr_ctrl && bus_wdata_i[CT_TX_CLR];

  uart_rx_fifo #(.DEPTH(RX_DEPTH), .DW(BYTE_W)) u_rx_fifo (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (rx_clr),
    .push_valid_i (rx_valid_i),
    .push_data_i  (rx_data_i),
    .push_ready_o (rx_ready_o),
    .pop_i        (rd_rxd),
    .head_o       (rx_head),
    .count_o      (rx_cnt),
    .count_next_o (rx_cnt_nxt),
    .drop_o       (rx_drop)
  );

  uart_tx_hold #(.DW(BYTE_W)) u_tx_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (tx_clr),
    .load_i      (wr_txd),
    .load_data_i (bus_wdata_i[BYTE_W-1:0]),
    .out_valid_o (tx_valid_o),
    .out_data_o  (tx_data_o),
    .out_ready_i (tx_ready_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata_i;
      if (rx_clr)       ovr_q <= 1'b0;
      else if (rx_drop) ovr_q <= 1'b1;
      // status read acknowledges, but a non-empty FIFO re-arms at once
      pend_q <= (pend_q && !rd_stat) || wr_txd || (rx_cnt_nxt != '0);
    end
  end

  always_comb begin
    stat              = '0;
    stat[ST_RX_AVAIL] = (rx_cnt != '0);
    stat[ST_RX_FULL]  = (rx_cnt == CNT_W'(RX_DEPTH));
    stat[ST_TX_EMPTY] = !tx_valid_o;
    stat[ST_TX_FULL]  = tx_valid_o;
    stat[ST_PEND]     = pend_q;
    stat[ST_OVERRUN]  = ovr_q;
  end

  always_comb begin
    unique case (idx)
      REG_RXD:  bus_rdata_o = (rx_cnt != '0) ? DATA_W'(rx_head) : '0;
      REG_TXD:  bus_rdata_o = DATA_W'(tx_data_o);
      REG_STAT: bus_rdata_o = stat;
      default:  bus_rdata_o = ctrl_q;
    endcase
  end

  assign irq_o = pend_q && ctrl_q[CT_IRQ_EN];
endmodule

// File: rtl/uart_regfile_sva.sv
module uart_regfile_sva #(
  parameter  int unsigned RX_DEPTH = 8,
  parameter  int unsigned BYTE_W   = 8,
  parameter  int unsigned DATA_W   = 32,
  localparam int unsigned CNT_W    = $clog2(RX_DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [3:0]        bus_addr_i,
  input logic              bus_re_i,
  input logic              bus_we_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic              rx_valid_i,
  input logic              rx_ready_o,
  input logic [BYTE_W-1:0] tx_data_o,
  input logic              tx_valid_o,
  input logic              tx_ready_i,
  input logic              irq_o,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [DATA_W-1:0] ctrl_i,
  input logic              pend_i,
  input logic              ovr_i
);
  logic ctrl_wr, rx_clr, tx_clr;
  assign ctrl_wr = bus_we_i && (bus_addr_i[3:2] == 2'd3);
  assign rx_clr  = ctrl_wr && bus_wdata_i[1];
  assign tx_clr  = ctrl_wr && bus_wdata_i[0];

  p_single_access_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_re_i && bus_we_i));

  p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CNT_W'(RX_DEPTH));

  p_drop_sets_ovr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !rx_ready_o && !rx_clr) |=> ovr_i);

  p_rx_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_clr |=> (cnt_i == '0) && !ovr_i && rx_ready_o);

  p_tx_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i && !tx_clr) |=> tx_valid_o && $stable(tx_data_o));

  p_tx_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_clr |=> !tx_valid_o);

  p_pend_nonempty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i != '0) |-> pend_i);

  p_irq_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ctrl_i[4]);
endmodule

bind uart_regfile uart_regfile_sva #(
  .RX_DEPTH(RX_DEPTH), .BYTE_W(BYTE_W), .DATA_W(DATA_W)
) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_addr_i  (bus_addr_i),
  .bus_re_i    (bus_re_i),
  .bus_we_i    (bus_we_i),
  .bus_wdata_i (bus_wdata_i),
  .rx_valid_i  (rx_valid_i),
  .rx_ready_o  (rx_ready_o),
  .tx_data_o   (tx_data_o),
  .tx_valid_o  (tx_valid_o),
  .tx_ready_i  (tx_ready_i),
  .irq_o       (irq_o),
  .cnt_i       (rx_cnt),
  .ctrl_i      (ctrl_q),
  .pend_i      (pend_q),
  .ovr_i       (ovr_q)
);

// File: tb/uart_regfile_bench.sv
module uart_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        re = 1'b0, we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  rxd = '0;
  logic        rxv = 1'b0;
  logic        rx_rdy;
  logic [7:0]  txd;
  logic        txv;
  logic        txr = 1'b0;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  // reference model state
  logic [7:0]  m_q[$];
  bit          m_txf = 0;
  logic [7:0]  m_txb = '0;
  logic [31:0] m_ctrl = '0;
  bit          m_pend = 0, m_ovr = 0;

  always #4 clk = ~clk;

  uart_regfile u_uart_regfile (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_re_i(re), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .rx_data_i(rxd), .rx_valid_i(rxv),
    .rx_ready_o(rx_rdy), .tx_data_o(txd), .tx_valid_o(txv), .tx_ready_i(txr),
    .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_status();
    logic [31:0] s = '0;
    s[0] = (m_q.size() != 0);
    s[1] = (m_q.size() == 8);
    s[2] = !m_txf;
    s[3] = m_txf;
    s[4] = m_pend;
    s[5] = m_ovr;
    return s;
  endfunction

  task automatic check_outs(input string tag);
    chk({tag, " R2 ready"}, 32'(rx_rdy), 32'(m_q.size() < 8));
    chk({tag, " R7 tx_valid"}, 32'(txv), 32'(m_txf));
    if (m_txf) chk({tag, " R7 tx_data"}, 32'(txd), 32'(m_txb));
    chk({tag, " R10 irq"}, 32'(irq), 32'(m_pend && m_ctrl[4]));
  endtask

  // inputs are already applied (after a negedge); check read data, advance model, step
  task automatic cycle(input string tag);
    int idx = int'(addr[3:2]);
    int osz;
    bit otxf, txwr, rxclr, txclr, pop, push, drop;
    logic [31:0] exp;
    #1;
    if (re) begin
      case (idx)
        0: exp = (m_q.size() != 0) ? 32'(m_q[0]) : 32'h0;
        1: exp = 32'(m_txb);
        2: exp = m_status();
        default: exp = m_ctrl;
      endcase
      chk({tag, " rdata"}, rdata, exp);
    end
    osz   = m_q.size();
    otxf  = m_txf;
    txwr  = we && idx == 1;
    rxclr = we && idx == 3 && wdata[1];
    txclr = we && idx == 3 && wdata[0];
    pop   = re && idx == 0 && osz > 0;
    push  = rxv && osz < 8;
    drop  = rxv && osz == 8;
    if (rxclr) begin
      m_q.delete();
      m_ovr = 0;
    end else begin
      if (pop) void'(m_q.pop_front());
      if (push) m_q.push_back(rxd);
      if (drop) m_ovr = 1;
    end
    if (txclr) m_txf = 0;
    else if (!otxf) begin
      if (txwr) begin
        m_txf = 1;
        m_txb = wdata[7:0];
      end
    end else if (txr) m_txf = 0;
    if (we && idx == 3) m_ctrl = wdata;
    m_pend = (m_pend && !(re && idx == 2)) || txwr || (m_q.size() != 0);
    @(posedge clk);
    @(negedge clk);
    check_outs(tag);
  endtask

  task automatic op(input string tag, input bit r, input bit w, input logic [3:0] a,
                    input logic [31:0] d, input bit v, input logic [7:0] b, input bit t);
    re = r; we = w; addr = a; wdata = d; rxv = v; rxd = b; txr = t;
    cycle(tag);
    re = 0; we = 0; rxv = 0; txr = 0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check_outs("R11 reset");
    op("R11 reset status", 1, 0, 4'h8, 0, 0, 0, 0);
    op("R11 reset ctrl", 1, 0, 4'hC, 0, 0, 0, 0);
    op("R3 empty read", 1, 0, 4'h0, 0, 0, 0, 0);
    op("R3 after empty", 1, 0, 4'h8, 0, 0, 0, 0);
    op("R1 ctrl write", 0, 1, 4'hC, 32'hA5A5_0010, 0, 0, 0);
    op("R1 ctrl read", 1, 0, 4'hF, 0, 0, 0, 0);
    // fill the FIFO to full, then one more
    for (int i = 0; i < 9; i++) op("R4 fill", 0, 0, 4'h0, 0, 1, 8'h30 + 8'(i), 0);
    op("R4 full status", 1, 0, 4'h8, 0, 0, 0, 0);
    op("R5 status write ignored", 0, 1, 4'h8, 32'h0, 0, 0, 0);
    op("R5 status after write", 1, 0, 4'h8, 0, 0, 0, 0);
    op("R9 status read nonempty", 1, 0, 4'h8, 0, 0, 0, 0);
    // drain with a push alongside every other pop to cross the wrap point
    for (int i = 0; i < 6; i++) op("R2 drain", 1, 0, 4'h0, 0, i[0], 8'h50 + 8'(i), 0);
    for (int i = 0; i < 6; i++) op("R2 drain rest", 1, 0, 4'h1 & 4'h0, 0, 0, 0, 0);
    op("R9 pending sticky", 1, 0, 4'h8, 0, 0, 0, 0);
    op("R9 pending cleared", 1, 0, 4'h8, 0, 0, 0, 0);
    op("R4 overrun sticky", 1, 0, 4'h8, 0, 0, 0, 0);
    // receive reset beats a same-cycle push
    op("R6 preload", 0, 0, 4'h0, 0, 1, 8'h77, 0);
    op("R6 clear with push", 0, 1, 4'hC, 32'h0000_0012, 1, 8'h88, 0);
    op("R6 after clear", 1, 0, 4'h8, 0, 0, 0, 0);
    op("R9 clear pend", 1, 0, 4'h8, 0, 0, 0, 0);
    // transmit path
    op("R7 tx load", 0, 1, 4'h4, 32'hFFFF_FF3C, 0, 0, 0);
    op("R7 tx hold", 0, 0, 4'h0, 0, 0, 0, 0);
    op("R7 tx write while full", 0, 1, 4'h4, 32'h0000_00C3, 0, 0, 0);
    op("R7 tx readback", 1, 0, 4'h4, 0, 0, 0, 0);
    op("R7 drain and write", 0, 1, 4'h4, 32'h0000_0011, 0, 0, 1);
    op("R7 tx load2", 0, 1, 4'h4, 32'h0000_0022, 0, 0, 0);
    op("R8 tx clear", 0, 1, 4'hC, 32'h0000_0001, 0, 0, 0);
    op("R8 status", 1, 0, 4'h8, 0, 0, 0, 0);
    op("R10 irq enable", 0, 1, 4'hC, 32'h0000_0010, 0, 0, 0);
    op("R10 tx write irq", 0, 1, 4'h4, 32'h0000_0099, 0, 0, 1);
    op("R10 ack", 1, 0, 4'h8, 0, 0, 0, 1);
    op("R10 quiet", 1, 0, 4'h8, 0, 0, 0, 0);
    // random phase against the model
    for (int n = 0; n < 3000; n++) begin
      int k = $urandom % 6;
      bit r = 0, w = 0;
      logic [31:0] d = $urandom;
      logic [3:0] a = 4'($urandom);
      if (k < 2) r = 1;
      else if (k < 4) w = 1;
      if (w && a[3:2] == 2'd3 && ($urandom % 4 != 0)) d[1:0] = 2'b00;
      op("R2 random", r, w, a, d, ($urandom % 3) != 0, 8'($urandom), ($urandom % 3) == 0);
    end
    finish_run();
  end
endmodule